// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency FFT Address Sequencer

This block drives the memory side of an in-place radix-2 decimation-in-frequency FFT. Given a transform size N = 2^k, it walks the stage, group and butterfly loops in hardware. Each accepted cycle it presents one butterfly: the two data indices the butterfly reads and writes back, the twiddle ROM index it needs, and the number of the stage it belongs to. The butterfly arithmetic, the twiddle ROM and the bit-reversed reordering of the result sit outside.

The address set leaves on a valid/ready stream. `out_valid` is high from the cycle after an accepted start until the last butterfly has been taken. A butterfly is accepted on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current address set is held unchanged, so the consumer may stall for any number of cycles. `start`, `log2n` and `done` are plain control pins. `done` pulses for one cycle once the transform is finished.

The transform size is taken from `log2n` only on the edge where a start is accepted. A start that arrives while a transform is in progress has no effect.

Top module: `fft_addr_gen`

## Requirements
- R1: After reset, `out_valid` and `done` are both 0 and stay 0 until a start is accepted.
- R2: A start seen while idle is accepted on that clock edge. On the next cycle `out_valid` is 1 and the first butterfly is presented with stage k, `idx0` = 0, `idx1` = N/2 and `tw_idx` = 0.
- R3: Stages are presented in the order k, k-1, …, 1, and `stage` carries the current stage number as an unsigned value. The stage number never goes up within a transform.
- R4: Within stage s, with span = 2^(s-1) and group size m = 2^s, groups are visited in the order base = 0, m, 2m, …, N-m. Within each group the butterfly counter b runs from 0 to span-1. For each butterfly, `idx0` = base + b and `idx1` = `idx0` + span.
- R5: The twiddle stride is 1 in stage k and doubles at each later stage. The twiddle index restarts at 0 in every group, so `tw_idx` = b · 2^(k-s).
- R6: A transform presents exactly k · N/2 butterflies. `out_valid` is 0 in the cycle after the last one is accepted.
- R7: `done` is 1 for exactly one cycle: the cycle right after the last butterfly of stage 1 is accepted. It is 0 at every other time.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `idx0`, `idx1`, `tw_idx` and `stage` keep their values into the next cycle.
- R9: A start that arrives while `out_valid` is 1 is ignored. This includes the cycle in which the last butterfly is accepted. The address sequence continues unchanged, and no new transform follows `done`.
- R10: `log2n` is a 4-bit unsigned value that sets k. Values below 3 are treated as 3 and values above 10 as 10, so N ranges from 8 to 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a transform when idle |
| log2n | input | 4 | log2 of the transform size, sampled when a start is accepted |
| out_ready | input | 1 | Consumer accepts the current butterfly |
| out_valid | output | 1 | A butterfly address set is presented |
| idx0 | output | 10 | First (upper) data index of the butterfly |
| idx1 | output | 10 | Second (lower) data index of the butterfly |
| tw_idx | output | 9 | Twiddle ROM index |
| stage | output | 4 | Current stage number, k down to 1 |
| done | output | 1 | One-cycle pulse after the final butterfly |

## Verification
Two events can land on the same edge and must be handled correctly together. The first is a start pulse arriving in the cycle where the final butterfly of stage 1 is accepted. The bench drives `start`, with a different `log2n`, exactly on that accepting cycle. It then requires three things: `done` rises, `out_valid` falls, and no new transform begins in the cycles that follow.

The second overlap is a start arriving mid-transform while the consumer is stalling. The bench pokes `start` during a pseudo-random `out_ready` pattern. It then requires that every later butterfly still matches the loop order computed independently in the bench.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;

  // Limits a requested log2 size to the supported range.
  function automatic int clamp_log2(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/fft_agu_loops.sv
module fft_agu_loops
  import fft_agu_pkg::*;
#(
  parameter int MIN_LOG2 = 3,
  parameter int MAX_LOG2 = 10,
  parameter int AW       = 10,
  parameter int LW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] log2n,
  input  logic          adv,
  output logic          busy,
  output logic [LW-1:0] stage,
  output logic [AW-1:0] span,
  output logic [AW-1:0] base,
  output logic [AW-1:0] bfly,
  output logic          grp_end,
  output logic          stage_end,
  output logic          done
);

  logic          busy_q, done_q;
  logic [LW-1:0] stage_q;
  logic [AW-1:0] span_q, base_q, bf_q;
  logic [AW:0]   npts_q;
  logic [AW:0]   grp_size;
  logic [LW-1:0] k_sel;
  logic          start_ok, last_bf, last_grp, last_stage, xfer_end;

  assign k_sel      = LW'(clamp_log2(int'(log2n), MIN_LOG2, MAX_LOG2));
  assign start_ok   = start && !busy_q;
  assign grp_size   = {span_q, 1'b0};
  assign last_bf    = (bf_q == span_q - AW'(1));
  assign last_grp   = (({1'b0, base_q} + grp_size) == npts_q);
  assign last_stage = (stage_q == LW'(1));
  assign grp_end    = adv && last_bf;
  assign stage_end  = grp_end && last_grp;
  assign xfer_end   = stage_end && last_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
      span_q  <= '0;
      base_q  <= '0;
      bf_q    <= '0;
      npts_q  <= '0;
    end else begin
      done_q <= xfer_end;
      if (start_ok) begin
        busy_q  <= 1'b1;
        stage_q <= k_sel;
        span_q  <= AW'(1) << (k_sel - LW'(1));
        npts_q  <= (AW+1)'(1) << k_sel;
        base_q  <= '0;
        bf_q    <= '0;
      end else if (adv) begin
        if (!last_bf) begin
          bf_q <= bf_q + AW'(1);
        end else begin
          bf_q <= '0;
          if (!last_grp) begin
            base_q <= base_q + grp_size[AW-1:0];
          end else begin
            base_q <= '0;
            if (last_stage) begin
              busy_q <= 1'b0;
            end else begin
              stage_q <= stage_q - LW'(1);
              span_q  <= span_q >> 1;
            end
          end
        end
      end
    end
  end

  assign busy  = busy_q;
  assign stage = stage_q;
  assign span  = span_q;
  assign base  = base_q;
  assign bfly  = bf_q;
  assign done  = done_q;

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  stage_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_end && !last_stage |=> stage_q == $past(stage_q) - LW'(1));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !xfer_end |=> busy_q);

  // R4
  bf_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> bf_q < span_q);

endmodule

// File: rtl/fft_agu_twiddle.sv
module fft_agu_twiddle #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          grp_end,
  input  logic          stage_end,
  output logic [TW-1:0] tw
);

  // The stride of stage 1 may wrap to zero; stage 1 only ever uses index 0.
  logic [TW-1:0] stride_q, tw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      tw_q     <= '0;
    end else if (load) begin
      stride_q <= TW'(1);
      tw_q     <= '0;
    end else if (adv) begin
      tw_q <= grp_end ? '0 : tw_q + stride_q;
      if (stage_end) stride_q <= stride_q << 1;
    end
  end

  assign tw = tw_q;

  // R5
  tw_group_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> tw_q == '0);

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter  int MIN_LOG2 = 3,
  parameter  int MAX_LOG2 = 10,
  localparam int AW       = MAX_LOG2,
  localparam int TW       = MAX_LOG2 - 1,
  localparam int LW       = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] log2n,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] idx0,
  output logic [AW-1:0] idx1,
  output logic [TW-1:0] tw_idx,
  output logic [LW-1:0] stage,
  output logic          done
);

  logic          busy, fire, load, grp_end, stage_end;
  logic [AW-1:0] span, base, bfly;

  assign fire = busy && out_ready;
  assign load = start && !busy;

  fft_agu_loops #(
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .AW(AW), .LW(LW)
  ) u_loops (
    .clk(clk), .rst_n(rst_n), .start(start), .log2n(log2n), .adv(fire),
    .busy(busy), .stage(stage), .span(span), .base(base), .bfly(bfly),
    .grp_end(grp_end), .stage_end(stage_end), .done(done)
  );

  fft_agu_twiddle #(.TW(TW)) u_twid (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(fire),
    .grp_end(grp_end), .stage_end(stage_end), .tw(tw_idx)
  );

  assign out_valid = busy;
  assign idx0      = base + bfly;
  assign idx1      = idx0 + span;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(idx0) && $stable(idx1)
                                && $stable(tw_idx) && $stable(stage));

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> idx1 > idx0);

endmodule

// File: tb/sim_fft_addr_gen.sv
module sim_fft_addr_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] log2n = 4'd0;
  logic       out_ready = 1'b1;
  logic       out_valid, done;
  logic [9:0] idx0, idx1;
  logic [8:0] tw_idx;
  logic [3:0] stage;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fft_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .log2n(log2n),
    .out_ready(out_ready), .out_valid(out_valid), .idx0(idx0), .idx1(idx1),
    .tw_idx(tw_idx), .stage(stage), .done(done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Runs one transform; poke_at = butterfly number on which start is re-driven (-1 none).
  task automatic run_fft(input int req, input int k, input bit stall,
                         input int poke_at, input string tag);
    int n = 1 << k;
    int cnt = 0;
    int total = k * n / 2;
    @(negedge clk);
    log2n = 4'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    log2n = 4'd7;
    for (int s = k; s >= 1; s--) begin
      int sp = 1 << (s - 1);
      for (int g = 0; g <= n - 2 * sp; g += 2 * sp) begin
        for (int b = 0; b < sp; b++) begin
          bit fired = 1'b0;
          int e0 = g + b;
          int e1 = g + b + sp;
          int et = b << (k - s);
          while (!fired) begin
            if (stall) begin step_lfsr(); out_ready = lfsr[0] | lfsr[3]; end
            else out_ready = 1'b1;
            start = (cnt == poke_at);
            log2n = start ? 4'd3 : 4'd7;
            #1;
            chk(out_valid == 1'b1, {tag, " R2 out_valid during run"}, int'(out_valid), 1);
            chk(int'(idx0) == e0, {tag, " R4 idx0"}, int'(idx0), e0);
            chk(int'(idx1) == e1, {tag, " R4 idx1"}, int'(idx1), e1);
            chk(int'(tw_idx) == et, {tag, " R5 tw_idx"}, int'(tw_idx), et);
            chk(int'(stage) == s, {tag, " R3 stage"}, int'(stage), s);
            chk(done == 1'b0, {tag, " R7 done low during run"}, int'(done), 0);
            if (!out_ready) chk(1'b1, {tag, " R8 stall cycle"}, 0, 0);
            fired = out_ready && out_valid;
            @(negedge clk);
            start = 1'b0;
          end
          cnt++;
        end
      end
    end
    out_ready = 1'b1;
    #1;
    chk(done == 1'b1, {tag, " R7 done pulse"}, int'(done), 1);
    chk(out_valid == 1'b0, {tag, " R6 no butterfly after last"}, int'(out_valid), 0);
    chk(cnt == total, {tag, " R6 butterfly count"}, cnt, total);
    @(negedge clk);
    #1;
    chk(done == 1'b0, {tag, " R7 done single cycle"}, int'(done), 0);
    chk(out_valid == 1'b0, {tag, " R9 no restart"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done idle after reset", int'(done), 0);
  endtask

  task automatic t_basic();       run_fft(3, 3, 1'b0, -1, "R2"); endtask
  task automatic t_start_on_last(); run_fft(4, 4, 1'b1, 31, "R9 last"); endtask
  task automatic t_start_mid();   run_fft(5, 5, 1'b1, 7, "R9 mid"); endtask
  task automatic t_clamp_low();   run_fft(1, 3, 1'b0, -1, "R10 low"); endtask
  task automatic t_clamp_high();  run_fft(15, 10, 1'b0, -1, "R10 high"); endtask
  task automatic t_big_stall();   run_fft(10, 10, 1'b1, 100, "R8 big"); endtask

  initial begin
    t_reset();
    t_basic();
    t_start_on_last();
    t_start_mid();
    t_clamp_low();
    t_clamp_high();
    t_big_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule